// File: doc/BRIEF.md
# DMA Channel Arbiter

This block decides which DMA channel the transfer engine starts next. Each cycle it looks at a vector of pending hardware service requests, one bit per channel, and at a per-channel arbitration group value. When the engine is idle and requests are pending, it grants exactly one channel. It then holds that grant, reports the engine as active and gives the number of the running channel, until the engine signals with a done pulse that the channel has finished.

A mode input selects between two selection policies. In fixed mode, the channel with the largest group value wins. In round-robin mode, the search starts just after the last granted channel and wraps around. A halt input stops new channel starts without disturbing a channel that is already running. The pending request vector is also driven out as two half-width words so that a status register bank can read it.

Top module: `dma_chan_arbiter`

## Requirements
- R1: While rst_ni is low, and at the first clock after it is released with no requests pending, active_o is 0, active_id_o is 0 and grant_o is all zeros.
- R2: With rr_mode_i = 0, the granted channel is the requesting channel with the largest group value. Channel n's group is grp_i[n*6 +: 6], compared unsigned. When several channels share that largest value, the highest channel number wins.
- R3: With rr_mode_i = 1, the granted channel is the first requesting channel found by searching upward from (last granted channel + 1), wrapping from 63 to 0. Group values have no effect in this mode. After reset the search starts at channel 0. A grant in either mode counts as the last granted channel.
- R4: A grant is taken at a clock edge where active_o is 0, halt_i is 0 and at least one request is pending. From that edge on, active_o is 1, active_id_o holds the winner and grant_o is one-hot with bit active_id_o set. While active_o is 0, grant_o is all zeros.
- R5: While active_o is 1 and done_i is 0, the grant, active_o and active_id_o stay unchanged, whatever req_i, grp_i or rr_mode_i do.
- R6: A clock edge with active_o = 1 and done_i = 1 clears active_o and grant_o. The engine is then idle for at least one cycle before the next grant.
- R7: While halt_i is 1, no grant starts. A channel that is already active stays active until done_i. The pending winner is granted at the first edge after halt_i returns to 0.
- R8: req_lo_o equals req_i[31:0] and req_hi_o equals req_i[63:32] in the same cycle, with no register between them.
- R9: done_i has no effect while active_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 64 | Pending service request per channel |
| grp_i | input | 384 | Packed 6-bit arbitration group per channel, channel n at bits n*6+5..n*6 |
| rr_mode_i | input | 1 | 1 selects round-robin, 0 selects fixed priority |
| halt_i | input | 1 | Blocks new grants |
| done_i | input | 1 | Engine pulse: the active channel has finished |
| grant_o | output | 64 | One-hot grant of the active channel |
| active_o | output | 1 | A channel is executing |
| active_id_o | output | 6 | Number of the executing channel |
| req_lo_o | output | 32 | Request status, channels 31..0 |
| req_hi_o | output | 32 | Request status, channels 63..32 |

## Verification
Assertions check on every cycle that the grant is one-hot and matches the active ID, that the grant and ID hold steady until done, that done ends the active period, that halt blocks a start from idle, and that both pickers only ever name a requesting channel. Only the bench's scenarios can show that the right channel wins. This covers the largest group value and its highest-index tie-break, the round-robin order and its wrap from 63 to 0, the indifference to group values in round-robin mode, and resumption after halt. The bench works these out with its own reference functions over single-channel sweeps, all-channel rotations and pseudo-random request and group patterns.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int unsigned NUM_CH_DEF = 64;
  localparam int unsigned GRP_W_DEF  = 6;
endpackage

// File: rtl/dma_arb_fixed_pick.sv
module dma_arb_fixed_pick #(
  parameter int unsigned NUM_CH = 64,
  parameter int unsigned GRP_W  = 6,
  localparam int unsigned ID_W  = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0]       req_i,
  input  logic [NUM_CH*GRP_W-1:0] grp_i,
  output logic                    valid_o,
  output logic [ID_W-1:0]         id_o
);
  logic [GRP_W-1:0] best;

  // ascending scan with >= leaves the highest index among equal maxima
  always_comb begin
    valid_o = 1'b0;
    id_o    = '0;
    best    = '0;
    for (int i = 0; i < int'(NUM_CH); i++) begin
      if (req_i[i] && (!valid_o || grp_i[i*GRP_W +: GRP_W] >= best)) begin
        valid_o = 1'b1;
        best    = grp_i[i*GRP_W +: GRP_W];
        id_o    = ID_W'(i);
      end
    end
  end

  always_comb begin
    if (valid_o) assert_fixed_pick_req_R2: assert (req_i[id_o]);
  end
endmodule

// File: rtl/dma_arb_rr_pick.sv
module dma_arb_rr_pick #(
  parameter int unsigned NUM_CH = 64,
  localparam int unsigned ID_W  = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] req_i,
  input  logic [ID_W-1:0]   last_i,
  output logic              valid_o,
  output logic [ID_W-1:0]   id_o
);
  always_comb begin
    valid_o = 1'b0;
    id_o    = '0;
    for (int k = 1; k <= int'(NUM_CH); k++) begin
      int unsigned idx;
      idx = (int'(last_i) + k) % NUM_CH;
      if (!valid_o && req_i[idx]) begin
        valid_o = 1'b1;
        id_o    = ID_W'(idx);
      end
    end
  end

  always_comb begin
    if (valid_o) assert_rr_pick_req_R3: assert (req_i[id_o]);
  end
endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
  import dma_arb_pkg::*;
#(
  parameter int unsigned NUM_CH = NUM_CH_DEF,
  parameter int unsigned GRP_W  = GRP_W_DEF,
  localparam int unsigned ID_W  = $clog2(NUM_CH),
  localparam int unsigned HALF  = NUM_CH / 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_CH-1:0]       req_i,
  input  logic [NUM_CH*GRP_W-1:0] grp_i,
  input  logic                    rr_mode_i,
  input  logic                    halt_i,
  input  logic                    done_i,
  output logic [NUM_CH-1:0]       grant_o,
  output logic                    active_o,
  output logic [ID_W-1:0]         active_id_o,
  output logic [HALF-1:0]         req_lo_o,
  output logic [NUM_CH-HALF-1:0]  req_hi_o
);
  logic            active_q;
  logic [ID_W-1:0] id_q, last_q;
  logic            fx_valid, rr_valid, pick_valid, start;
  logic [ID_W-1:0] fx_id, rr_id, pick_id;

  dma_arb_fixed_pick #(.NUM_CH(NUM_CH), .GRP_W(GRP_W)) u_fixed (
    .req_i   (req_i),
    .grp_i   (grp_i),
    .valid_o (fx_valid),
    .id_o    (fx_id)
  );

  dma_arb_rr_pick #(.NUM_CH(NUM_CH)) u_rr (
    .req_i   (req_i),
    .last_i  (last_q),
    .valid_o (rr_valid),
    .id_o    (rr_id)
  );

  assign pick_valid = rr_mode_i ? rr_valid : fx_valid;
  assign pick_id    = rr_mode_i ? rr_id    : fx_id;
  assign start      = !active_q && !halt_i && pick_valid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      id_q     <= '0;
      last_q   <= ID_W'(NUM_CH - 1);
    end else if (start) begin
      active_q <= 1'b1;
      id_q     <= pick_id;
      last_q   <= pick_id;
    end else if (active_q && done_i) begin
      active_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < int'(NUM_CH); g++) begin : g_grant
    assign grant_o[g] = active_q && (id_q == ID_W'(g));
  end

  assign active_o    = active_q;
  assign active_id_o = id_q;
  assign req_lo_o    = req_i[HALF-1:0];
  assign req_hi_o    = req_i[NUM_CH-1:HALF];

  assert_grant_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> ($countones(grant_o) == 1) && grant_o[active_id_o]);
  assert_idle_no_grant_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> (grant_o == '0));
  assert_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && !halt_i && (|req_i)) |=> active_o);
  assert_granted_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> ((($past(req_i) >> active_id_o) & 1) != 0));
  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !done_i) |=> active_o && $stable(active_id_o) && $stable(grant_o));
  assert_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && done_i) |=> !active_o);
  assert_halt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && halt_i) |=> !active_o);
endmodule

// File: tb/dma_chan_arbiter_test.sv
`timescale 1ns/1ps
module dma_chan_arbiter_test;
  localparam int N = 64;
  localparam int GW = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    req = '0;
  logic [N*GW-1:0] grp = '0;
  logic            rr = 1'b0, halt = 1'b0, done = 1'b0;
  logic [N-1:0]    grant;
  logic            active;
  logic [5:0]      active_id;
  logic [31:0]     req_lo, req_hi;

  int tests = 0, fails = 0;
  bit finished = 0;
  int last_id = N - 1;
  logic [63:0] seed = 64'h9E3779B97F4A7C15;

  always #10 clk = ~clk;

  dma_chan_arbiter uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .grp_i(grp),
    .rr_mode_i(rr), .halt_i(halt), .done_i(done),
    .grant_o(grant), .active_o(active), .active_id_o(active_id),
    .req_lo_o(req_lo), .req_hi_o(req_hi)
  );

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [63:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    return seed;
  endfunction

  // reference: descending scan, strictly greater keeps highest index on ties
  function automatic int ref_fixed(logic [N-1:0] r, logic [N*GW-1:0] g);
    int best = -1, id = -1;
    for (int i = N - 1; i >= 0; i--)
      if (r[i] && int'(g[i*GW +: GW]) > best) begin
        best = int'(g[i*GW +: GW]);
        id = i;
      end
    return id;
  endfunction

  function automatic int ref_rr(logic [N-1:0] r, int last);
    for (int k = 1; k <= N; k++)
      if (r[(last + k) % N]) return (last + k) % N;
    return -1;
  endfunction

  // one grant/hold/done cycle; requests and groups are driven at a negedge
  task automatic round(logic [N-1:0] r, logic [N*GW-1:0] g, logic m, string tag);
    int exp;
    req = r; grp = g; rr = m; done = 0; halt = 0;
    exp = m ? ref_rr(r, last_id) : ref_fixed(r, g);
    #1;
    chk("R8 lo", 64'(req_lo), 64'(r[31:0]));
    chk("R8 hi", 64'(req_hi), 64'(r[63:32]));
    @(negedge clk);
    chk({tag, " active"}, 64'(active), 64'd1);
    chk({tag, " id"}, 64'(active_id), 64'(exp));
    chk("R4 onehot", grant, 64'd1 << exp);
    last_id = exp;
    req = rnd(); grp = {6{rnd()}}; rr = ~m;
    @(negedge clk);
    chk("R5 held id", 64'(active_id), 64'(exp));
    chk("R5 held act", 64'(active), 64'd1);
    done = 1;
    @(negedge clk);
    done = 0; req = '0;
    chk("R6 idle", 64'(active), 64'd0);
    chk("R6 grant clr", grant, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 act", 64'(active), 0);
    chk("R1 grant", grant, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 id", 64'(active_id), 0);
    chk("R1 act rel", 64'(active), 0);

    // R9: done while idle does nothing
    done = 1;
    @(negedge clk);
    chk("R9 idle done", 64'(active), 0);
    done = 0;

    // R3 first search after reset starts at channel 0
    round({N{1'b1}}, '0, 1'b1, "R3 start0");

    // R2 single-channel sweep
    for (int c = 0; c < N; c++) round(64'd1 << c, {6{rnd()}}, 1'b0, "R2 single");

    // R2 all equal groups: highest channel wins
    round({N{1'b1}}, {N{6'd17}}, 1'b0, "R2 tie");
    round(64'h0000_0000_0000_0011, {N{6'd0}}, 1'b0, "R2 tie0");

    // R3 full rotation with wrap, groups random (ignored)
    for (int k = 0; k < N + 3; k++) round({N{1'b1}}, {6{rnd()}}, 1'b1, "R3 rot");
    round(64'h8000_0000_0000_0001, {N{6'd63}}, 1'b1, "R3 wrap");

    // random patterns in both modes
    for (int k = 0; k < 200; k++) begin
      logic [63:0] r;
      r = rnd() & rnd();
      if (r == 0) r = 64'd1 << (k % N);
      round(r, {6{rnd()}}, k[0], k[0] ? "R3 rand" : "R2 rand");
    end

    // R7: halt from idle blocks, then resumes
    begin
      logic [63:0] r;
      int exp;
      r = 64'h0000_0F00_0000_00F0;
      grp = {6{rnd()}}; rr = 0; halt = 1; req = r;
      exp = ref_fixed(r, grp);
      repeat (3) begin
        @(negedge clk);
        chk("R7 halted", 64'(active), 0);
      end
      halt = 0;
      @(negedge clk);
      chk("R7 resume act", 64'(active), 1);
      chk("R7 resume id", 64'(active_id), 64'(exp));
      last_id = exp;
      halt = 1;
      repeat (2) begin
        @(negedge clk);
        chk("R7 runs on", 64'(active), 1);
        chk("R7 runs id", 64'(active_id), 64'(exp));
      end
      done = 1;
      @(negedge clk);
      done = 0;
      chk("R7 done", 64'(active), 0);
      @(negedge clk);
      chk("R7 still halted", 64'(active), 0);
      halt = 0; req = '0;
      @(negedge clk);
    end

    // R9: done asserted together with a new request in idle still grants
    begin
      int exp;
      rr = 1; req = 64'h0000_0000_0100_0000; done = 1;
      exp = ref_rr(req, last_id);
      @(negedge clk);
      done = 0;
      chk("R9 grant", 64'(active_id), 64'(exp));
      chk("R9 act", 64'(active), 1);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule